// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block turns an exception request or a return-from-exception strobe into a program-counter redirect and the matching updates of the processor's exception state registers. An exception request carries a 4-bit vector number, the address of the faulting instruction, a flag saying whether that instruction sat in a branch delay slot, and the high-prefix selector that picks the handler base. The block holds four registers: the live status word, the saved status word, the saved return address and the effective-address register. It drives a one-cycle redirect with its target, a one-cycle pulse that tells the fetch stage to drop any pending delay-slot state, a debug-halt pulse for breakpoint traps and an error pulse for vector numbers it does not know.

The sequencer is a five-state machine. IDLE accepts work and is the only state in which `ready_o` is high. From IDLE, a request with a handler vector moves to ENTRY, a trap vector moves to HALT, any other vector moves to FAULT, and a return strobe with no exception request moves to RETURN. ENTRY, RETURN, HALT and FAULT each last exactly one cycle and always go back to IDLE. Register updates take effect on the clock edge that leaves ENTRY or RETURN. A status-register write port loads the live status word when no entry or return is updating it.

Top module: `exc_seq_top`

## Requirements
- R1: After reset, the status word equals the parameter `SR_RESET` (default 0x0000_8001), the saved status, the saved return address and the effective-address register are zero, `ready_o` is 1 and every pulse output is 0.
- R2: Vector encodings are reset 0x1, bus error 0x2, alignment 0x6, illegal 0x7, range 0xB, syscall 0xC, floating-point 0xD and trap 0xE. For a handler vector accepted at edge N, `redirect_valid_o` is 1 for exactly the cycle after edge N, with target (prefix ? 0xF000_0000 : 0) + (vector << 8).
- R3: For floating-point and syscall, the saved return address becomes faulting PC + 4, or the faulting PC itself when the delay-slot flag is set.
- R4: For bus error, alignment, illegal and range, the saved return address becomes the faulting PC, or faulting PC − 4 (modulo 2^32) when the delay-slot flag is set.
- R5: A reset-vector entry leaves the saved return address unchanged.
- R6: On entry, the saved status word takes the previous status word, and status bit 13 (the delay-slot-exception bit) takes the delay-slot flag. All other status bits keep their values.
- R7: A trap vector gives a one-cycle `dbg_halt_o` with `dbg_halt_pc_o` equal to the faulting PC. It gives no redirect and changes no register.
- R8: A return loads the status word from the saved status word with bit 15 (the fixed-one bit) forced to 1, and redirects for one cycle to the saved return address.
- R9: `clr_next_dslot_o` pulses in the same cycle as every entry redirect and every return redirect, and at no other time.
- R10: An illegal-instruction entry writes the faulting PC into the effective-address register. Other vectors leave it unchanged.
- R11: Any vector number outside the R2 list gives a one-cycle `vec_err_o`, with no redirect, no halt and no register change.
- R12: Requests that arrive while `ready_o` is 0 are ignored. When an exception request and a return strobe arrive together, the exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 1 | Exception request |
| exc_vec_i | input | 4 | Vector number |
| exc_pc_i | input | XLEN | Faulting instruction address |
| exc_dslot_i | input | 1 | Faulting instruction sat in a delay slot |
| exc_prefix_i | input | 1 | Selects the high handler base |
| rfe_req_i | input | 1 | Return-from-exception strobe |
| sr_wr_en_i | input | 1 | Status-word write enable |
| sr_wr_data_i | input | XLEN | Status-word write data |
| ready_o | output | 1 | Sequencer idle, accepts a request |
| redirect_valid_o | output | 1 | PC redirect strobe |
| redirect_pc_o | output | XLEN | Redirect target |
| clr_next_dslot_o | output | 1 | Drop pending delay-slot state |
| dbg_halt_o | output | 1 | Breakpoint halt pulse |
| dbg_halt_pc_o | output | XLEN | Address of the trapping instruction |
| vec_err_o | output | 1 | Unknown vector pulse |
| sr_o | output | XLEN | Live status word |
| esr_o | output | XLEN | Saved status word |
| epcr_o | output | XLEN | Saved return address |
| eear_o | output | XLEN | Effective-address register |

## Verification
The bench sweeps all sixteen vector codes against both delay-slot values and both prefix settings. Before each request it loads a status word whose bit 13 is the opposite of the flag about to be sent, so a missing delay-slot copy shows up. The sweep separates the three saved-address rules (plus four, unchanged, keep) and the four kinds of outcome (handler, halt, error, silence). Every successful entry is followed by a return, which shows whether the saved status and return address round-trip with the fixed-one bit forced. A low faulting PC checks that the minus-four adjustment wraps. Separate cases check a request held through the busy cycle and a request that coincides with a return strobe.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int VEC_W       = 4;
    localparam int SR_DSX_BIT  = 13;
    localparam int SR_FO_BIT   = 15;

    localparam logic [VEC_W-1:0] V_RESET   = 4'h1;
    localparam logic [VEC_W-1:0] V_BUSERR  = 4'h2;
    localparam logic [VEC_W-1:0] V_ALIGN   = 4'h6;
    localparam logic [VEC_W-1:0] V_ILLEGAL = 4'h7;
    localparam logic [VEC_W-1:0] V_RANGE   = 4'hB;
    localparam logic [VEC_W-1:0] V_SYSCALL = 4'hC;
    localparam logic [VEC_W-1:0] V_FPE     = 4'hD;
    localparam logic [VEC_W-1:0] V_TRAP    = 4'hE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_RETURN,
        ST_HALT,
        ST_FAULT
    } seq_state_e;

    typedef enum logic [1:0] {
        K_BAD,
        K_HANDLER,
        K_TRAP
    } vec_kind_e;

    typedef enum logic [1:0] {
        PC_KEEP,
        PC_NEXT,
        PC_SAME
    } pc_rule_e;

    function automatic vec_kind_e vec_kind(input logic [VEC_W-1:0] v);
        vec_kind_e k;
        case (v)
            V_RESET, V_BUSERR, V_ALIGN, V_ILLEGAL,
            V_RANGE, V_SYSCALL, V_FPE: k = K_HANDLER;
            V_TRAP:                    k = K_TRAP;
            default:                   k = K_BAD;
        endcase
        return k;
    endfunction

    function automatic pc_rule_e pc_rule(input logic [VEC_W-1:0] v);
        pc_rule_e r;
        case (v)
            V_SYSCALL, V_FPE:                       r = PC_NEXT;
            V_BUSERR, V_ALIGN, V_ILLEGAL, V_RANGE:  r = PC_SAME;
            default:                                r = PC_KEEP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/exc_target_calc.sv
module exc_target_calc
    import exc_seq_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000,
    parameter int              VEC_SHIFT = 8
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic             dslot_i,
    input  logic             prefix_i,
    output logic [XLEN-1:0]  handler_o,
    output logic [XLEN-1:0]  saved_pc_o,
    output logic             save_epcr_o,
    output logic             set_eear_o
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    pc_rule_e        rule;

    assign base      = prefix_i ? HI_BASE : '0;
    assign offset    = XLEN'(vec_i) << VEC_SHIFT;
    assign handler_o = base + offset;
    assign rule      = pc_rule(vec_i);
    assign set_eear_o = (vec_i == V_ILLEGAL);

    always_comb begin
        saved_pc_o  = pc_i;
        save_epcr_o = 1'b0;
        unique case (rule)
            PC_NEXT: begin
                save_epcr_o = 1'b1;
                saved_pc_o  = dslot_i ? pc_i : pc_i + INSN_BYTES;
            end
            PC_SAME: begin
                save_epcr_o = 1'b1;
                saved_pc_o  = dslot_i ? pc_i - INSN_BYTES : pc_i;
            end
            PC_KEEP: begin
                save_epcr_o = 1'b0;
                saved_pc_o  = pc_i;
            end
            default: begin
                save_epcr_o = 1'b0;
                saved_pc_o  = pc_i;
            end
        endcase
    end

endmodule

// File: rtl/exc_sysregs.sv
module exc_sysregs
    import exc_seq_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] SR_RESET = 32'h0000_8001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_we_i,
    input  logic            ret_we_i,
    input  logic            sr_wr_en_i,
    input  logic [XLEN-1:0] sr_wr_data_i,
    input  logic            dslot_i,
    input  logic            save_epcr_i,
    input  logic [XLEN-1:0] saved_pc_i,
    input  logic            set_eear_i,
    input  logic [XLEN-1:0] fault_pc_i,
    output logic [XLEN-1:0] sr_o,
    output logic [XLEN-1:0] esr_o,
    output logic [XLEN-1:0] epcr_o,
    output logic [XLEN-1:0] eear_o
);

    logic [XLEN-1:0] sr_q, esr_q, epcr_q, eear_q;
    logic [XLEN-1:0] sr_entry, sr_return;

    always_comb begin
        sr_entry             = sr_q;
        sr_entry[SR_DSX_BIT] = dslot_i;
        sr_return            = esr_q;
        sr_return[SR_FO_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= SR_RESET;
            esr_q  <= '0;
            epcr_q <= '0;
            eear_q <= '0;
        end else if (entry_we_i) begin
            sr_q  <= sr_entry;
            esr_q <= sr_q;
            if (save_epcr_i) epcr_q <= saved_pc_i;
            if (set_eear_i)  eear_q <= fault_pc_i;
        end else if (ret_we_i) begin
            sr_q <= sr_return;
        end else if (sr_wr_en_i) begin
            sr_q <= sr_wr_data_i;
        end
    end

    assign sr_o   = sr_q;
    assign esr_o  = esr_q;
    assign epcr_o = epcr_q;
    assign eear_o = eear_q;

    p_esr_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_we_i |=> esr_q == $past(sr_q))
        else $error("saved status did not take previous status");

    p_dsx_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_we_i |=> sr_q[SR_DSX_BIT] == $past(dslot_i))
        else $error("delay-slot bit not updated on entry");

    p_fo_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_we_i |=> sr_q[SR_FO_BIT])
        else $error("fixed-one bit clear after return");

    p_entry_ret_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(entry_we_i && ret_we_i))
        else $error("entry and return together");

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req_i,
    input  logic [VEC_W-1:0] exc_vec_i,
    input  logic [XLEN-1:0]  exc_pc_i,
    input  logic             exc_dslot_i,
    input  logic             exc_prefix_i,
    input  logic             rfe_req_i,
    output logic             ready_o,
    output logic             in_entry_o,
    output logic             in_return_o,
    output logic             halt_o,
    output logic             err_o,
    output logic [VEC_W-1:0] cap_vec_o,
    output logic [XLEN-1:0]  cap_pc_o,
    output logic             cap_dslot_o,
    output logic             cap_prefix_o
);

    seq_state_e state_q, state_d;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && exc_req_i;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (exc_req_i) begin
                    unique case (vec_kind(exc_vec_i))
                        K_HANDLER: state_d = ST_ENTRY;
                        K_TRAP:    state_d = ST_HALT;
                        K_BAD:     state_d = ST_FAULT;
                        default:   state_d = ST_FAULT;
                    endcase
                end else if (rfe_req_i) begin
                    state_d = ST_RETURN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ENTRY, ST_RETURN, ST_HALT, ST_FAULT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vec_o    <= '0;
            cap_pc_o     <= '0;
            cap_dslot_o  <= 1'b0;
            cap_prefix_o <= 1'b0;
        end else if (accept) begin
            cap_vec_o    <= exc_vec_i;
            cap_pc_o     <= exc_pc_i;
            cap_dslot_o  <= exc_dslot_i;
            cap_prefix_o <= exc_prefix_i;
        end
    end

    always_comb begin
        ready_o     = 1'b0;
        in_entry_o  = 1'b0;
        in_return_o = 1'b0;
        halt_o      = 1'b0;
        err_o       = 1'b0;
        unique case (state_q)
            ST_IDLE:   ready_o     = 1'b1;
            ST_ENTRY:  in_entry_o  = 1'b1;
            ST_RETURN: in_return_o = 1'b1;
            ST_HALT:   halt_o      = 1'b1;
            ST_FAULT:  err_o       = 1'b1;
            default:   ready_o     = 1'b0;
        endcase
    end

    p_one_cycle_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> ready_o)
        else $error("busy state lasted more than one cycle");

    p_busy_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (cap_pc_o == $past(cap_pc_o)) && (cap_vec_o == $past(cap_vec_o)))
        else $error("request captured while busy");

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_entry_o, in_return_o, halt_o, err_o}))
        else $error("more than one action pulse");

endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
    import exc_seq_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] SR_RESET  = 32'h0000_8001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req_i,
    input  logic [3:0]       exc_vec_i,
    input  logic [XLEN-1:0]  exc_pc_i,
    input  logic             exc_dslot_i,
    input  logic             exc_prefix_i,
    input  logic             rfe_req_i,
    input  logic             sr_wr_en_i,
    input  logic [XLEN-1:0]  sr_wr_data_i,
    output logic             ready_o,
    output logic             redirect_valid_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic             clr_next_dslot_o,
    output logic             dbg_halt_o,
    output logic [XLEN-1:0]  dbg_halt_pc_o,
    output logic             vec_err_o,
    output logic [XLEN-1:0]  sr_o,
    output logic [XLEN-1:0]  esr_o,
    output logic [XLEN-1:0]  epcr_o,
    output logic [XLEN-1:0]  eear_o
);

    logic             in_entry, in_return;
    logic [VEC_W-1:0] cap_vec;
    logic [XLEN-1:0]  cap_pc;
    logic             cap_dslot, cap_prefix;
    logic [XLEN-1:0]  handler_pc, saved_pc;
    logic             save_epcr, set_eear;

    exc_seq_fsm #(.XLEN(XLEN)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_req_i    (exc_req_i),
        .exc_vec_i    (exc_vec_i),
        .exc_pc_i     (exc_pc_i),
        .exc_dslot_i  (exc_dslot_i),
        .exc_prefix_i (exc_prefix_i),
        .rfe_req_i    (rfe_req_i),
        .ready_o      (ready_o),
        .in_entry_o   (in_entry),
        .in_return_o  (in_return),
        .halt_o       (dbg_halt_o),
        .err_o        (vec_err_o),
        .cap_vec_o    (cap_vec),
        .cap_pc_o     (cap_pc),
        .cap_dslot_o  (cap_dslot),
        .cap_prefix_o (cap_prefix)
    );

    exc_target_calc #(
        .XLEN(XLEN), .HI_BASE(HI_BASE), .VEC_SHIFT(VEC_SHIFT)
    ) u_calc (
        .vec_i       (cap_vec),
        .pc_i        (cap_pc),
        .dslot_i     (cap_dslot),
        .prefix_i    (cap_prefix),
        .handler_o   (handler_pc),
        .saved_pc_o  (saved_pc),
        .save_epcr_o (save_epcr),
        .set_eear_o  (set_eear)
    );

    exc_sysregs #(.XLEN(XLEN), .SR_RESET(SR_RESET)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_we_i   (in_entry),
        .ret_we_i     (in_return),
        .sr_wr_en_i   (sr_wr_en_i),
        .sr_wr_data_i (sr_wr_data_i),
        .dslot_i      (cap_dslot),
        .save_epcr_i  (save_epcr),
        .saved_pc_i   (saved_pc),
        .set_eear_i   (set_eear),
        .fault_pc_i   (cap_pc),
        .sr_o         (sr_o),
        .esr_o        (esr_o),
        .epcr_o       (epcr_o),
        .eear_o       (eear_o)
    );

    assign redirect_valid_o = in_entry | in_return;
    assign redirect_pc_o    = in_return ? epcr_o : handler_pc;
    assign clr_next_dslot_o = in_entry | in_return;
    assign dbg_halt_pc_o    = cap_pc;

    p_trap_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halt_o |=> $stable(epcr_o) && $stable(esr_o) && $stable(eear_o))
        else $error("trap changed exception registers");

    p_bad_keeps_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err_o |=> $stable(epcr_o) && $stable(esr_o) && $stable(eear_o))
        else $error("unknown vector changed exception registers");

    p_handler_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_entry |-> redirect_pc_o[VEC_SHIFT-1:0] == '0)
        else $error("handler target not vector aligned");

    p_redirect_followed_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_next_dslot_o |=> !clr_next_dslot_o && ready_o)
        else $error("delay-slot clear held longer than one cycle");

endmodule

// File: tb/exc_seq_top_tb_top.sv
module exc_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_vec = '0;
    logic [31:0] exc_pc = '0;
    logic        exc_dslot = 1'b0;
    logic        exc_prefix = 1'b0;
    logic        rfe_req = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [31:0] sr_wr_data = '0;
    logic        ready, redir_v, clr_ds, halt, verr;
    logic [31:0] redir_pc, halt_pc, sr, esr, epcr, eear;

    int checks = 0;
    int fails  = 0;

    logic [31:0] sr_m, esr_m, epcr_m, eear_m;

    always #5 clk = ~clk;

    exc_seq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .exc_req_i(exc_req), .exc_vec_i(exc_vec), .exc_pc_i(exc_pc),
        .exc_dslot_i(exc_dslot), .exc_prefix_i(exc_prefix),
        .rfe_req_i(rfe_req), .sr_wr_en_i(sr_wr_en), .sr_wr_data_i(sr_wr_data),
        .ready_o(ready), .redirect_valid_o(redir_v), .redirect_pc_o(redir_pc),
        .clr_next_dslot_o(clr_ds), .dbg_halt_o(halt), .dbg_halt_pc_o(halt_pc),
        .vec_err_o(verr), .sr_o(sr), .esr_o(esr), .epcr_o(epcr), .eear_o(eear)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [3:0] v);
        // 0 bad, 1 handler, 2 trap
        if (v == 4'h1 || v == 4'h2 || v == 4'h6 || v == 4'h7 ||
            v == 4'hB || v == 4'hC || v == 4'hD) return 1;
        if (v == 4'hE) return 2;
        return 0;
    endfunction

    task automatic chk_regs(input string req);
        chk(req, "sr",   sr,   sr_m);
        chk(req, "esr",  esr,  esr_m);
        chk(req, "epcr", epcr, epcr_m);
        chk(req, "eear", eear, eear_m);
    endtask

    task automatic write_sr(input logic [31:0] v);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = v;
        @(negedge clk);
        sr_wr_en = 1'b0;
        sr_m = v;
    endtask

    task automatic do_exc(input logic [3:0] v, input logic [31:0] pc,
                          input logic ds, input logic pre, input logic with_rfe);
        int k;
        string rq;
        k = kind_of(v);
        @(negedge clk);
        exc_req = 1'b1; exc_vec = v; exc_pc = pc; exc_dslot = ds;
        exc_prefix = pre; rfe_req = with_rfe;
        @(negedge clk);
        exc_req = 1'b0; rfe_req = 1'b0;
        chk("R12", "ready busy", {31'd0, ready}, 32'd0);
        if (k == 1) begin
            chk("R2", "redirect valid", {31'd0, redir_v}, 32'd1);
            chk("R2", "handler target", redir_pc,
                (pre ? 32'hF000_0000 : 32'h0) + (32'(v) << 8));
            chk("R9", "clear dslot", {31'd0, clr_ds}, 32'd1);
        end else if (k == 2) begin
            chk("R7", "halt", {31'd0, halt}, 32'd1);
            chk("R7", "halt pc", halt_pc, pc);
            chk("R7", "no redirect", {30'd0, redir_v, clr_ds}, 32'd0);
        end else begin
            chk("R11", "err", {31'd0, verr}, 32'd1);
            chk("R11", "no redirect/halt", {30'd0, redir_v, halt}, 32'd0);
        end
        if (k == 1) begin
            esr_m = sr_m;
            sr_m[13] = ds;
            if (v == 4'hC || v == 4'hD)
                epcr_m = ds ? pc : pc + 32'd4;
            else if (v == 4'h2 || v == 4'h6 || v == 4'h7 || v == 4'hB)
                epcr_m = ds ? pc - 32'd4 : pc;
            if (v == 4'h7) eear_m = pc;
        end
        @(negedge clk);
        chk("R9", "pulses idle", {28'd0, redir_v, clr_ds, halt, verr}, 32'd0);
        chk("R12", "ready back", {31'd0, ready}, 32'd1);
        if (k == 1) begin
            if (v == 4'hC || v == 4'hD)     rq = "R3";
            else if (v == 4'h1)             rq = "R5";
            else                            rq = "R4";
            chk(rq, "epcr", epcr, epcr_m);
            chk("R6", "sr", sr, sr_m);
            chk("R6", "esr", esr, esr_m);
            chk("R10", "eear", eear, eear_m);
        end else begin
            chk_regs(k == 2 ? "R7" : "R11");
        end
    endtask

    task automatic do_rfe();
        @(negedge clk);
        rfe_req = 1'b1;
        @(negedge clk);
        rfe_req = 1'b0;
        chk("R8", "return redirect", {31'd0, redir_v}, 32'd1);
        chk("R8", "return target", redir_pc, epcr_m);
        chk("R9", "clear dslot on return", {31'd0, clr_ds}, 32'd1);
        sr_m = esr_m | 32'h0000_8000;
        @(negedge clk);
        chk("R8", "status restored", sr, sr_m);
        chk("R8", "saved regs kept", epcr, epcr_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        sr_m = 32'h0000_8001; esr_m = '0; epcr_m = '0; eear_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_regs("R1");
        chk("R1", "ready", {31'd0, ready}, 32'd1);
        chk("R1", "pulses", {28'd0, redir_v, clr_ds, halt, verr}, 32'd0);

        for (int v = 0; v < 16; v++) begin
            for (int ds = 0; ds < 2; ds++) begin
                for (int pre = 0; pre < 2; pre++) begin
                    logic [31:0] pc;
                    pc = 32'h1000_0000 + 32'(v) * 32'h40 + 32'(ds) * 32'h8 + 32'(pre) * 32'h4;
                    write_sr(32'h5A00_0000 | (32'(v) * 32'h0111) |
                             (32'(1 - ds) << 13) | (32'(pre) << 20));
                    do_exc(4'(v), pc, ds[0], pre[0], 1'b0);
                    if (kind_of(4'(v)) == 1) do_rfe();
                end
            end
        end

        // minus-four wraps at address zero
        write_sr(32'h0000_0000);
        do_exc(4'h6, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        chk("R4", "wrap", epcr, 32'hFFFF_FFFC);

        // exception beats simultaneous return
        do_exc(4'hC, 32'h2000_0100, 1'b0, 1'b1, 1'b1);

        // request held through busy cycle is ignored
        @(negedge clk);
        exc_req = 1'b1; exc_vec = 4'hD; exc_pc = 32'h3000_0000;
        exc_dslot = 1'b0; exc_prefix = 1'b0;
        @(negedge clk);
        exc_vec = 4'h7; exc_pc = 32'h4444_0000;
        @(posedge clk);
        exc_req = 1'b0;
        esr_m = sr_m; sr_m[13] = 1'b0; epcr_m = 32'h3000_0004;
        @(negedge clk);
        chk("R12", "no second redirect", {31'd0, redir_v}, 32'd0);
        chk("R12", "eear untouched", eear, eear_m);
        chk("R12", "epcr first only", epcr, epcr_m);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule